// File: doc/BRIEF.md
# Fully Associative Branch Target Buffer

This block sits in the instruction fetch stage. Each cycle the fetch address is compared against every stored branch address at once. A match means the instruction being fetched is a known branch. If the stored outcome history for that branch favours taken, the stored target becomes the next fetch address in the same cycle. Otherwise the next fetch address is the sequential one, four bytes on.

When a branch resolves later in the pipeline, its address, real target and outcome arrive on an update port. A branch that is already stored has its target replaced and its history shifted. A branch that is not stored claims an entry: the lowest-numbered empty slot if one exists, otherwise a round-robin victim. The branch is still executed downstream, which validates the prediction. Recovery from a wrong prediction is handled elsewhere.

A synchronous reset and a flush input both empty the buffer.

Top module: `fa_btb`

## Requirements
- R1: After reset no fetch address hits, `pred_taken` is 0 and `next_pc` equals `fetch_pc + 4`.
- R2: `hit` is 1 in the same cycle exactly when `fetch_pc` equals the full stored address of a valid entry.
- R3: On a hit whose history predicts taken, `next_pc` is the stored target and `pred_taken` is 1.
- R4: On a miss, or on a hit predicting not taken, `next_pc` is `fetch_pc + 4` and `pred_taken` is 0.
- R5: Each entry keeps an `HIST_W`-bit outcome history, with a 1 meaning taken. Prediction is taken when at least half of the bits are 1. A newly allocated entry fills every bit with the outcome. A refresh shifts the outcome in at bit 0 and drops the oldest bit.
- R6: An update whose address is already stored overwrites that entry's target and shifts its history, and it does not take a new entry.
- R7: An update whose address is not stored writes the lowest-numbered invalid entry.
- R8: When all entries are valid, a missing update replaces the entry named by a round-robin pointer. The pointer starts at 0, moves up by one after each such replacement and wraps from `ENTRIES-1` to 0.
- R9: A lookup in the same cycle as an update to the same address sees the contents from before the update. The write is visible from the next cycle.
- R10: `flush` invalidates every entry and returns the round-robin pointer to 0. It overrides an update in the same cycle.
- R11: No two valid entries hold the same address, so at most one entry matches a lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all entries |
| fetch_pc | input | ADDR_W | Current fetch address |
| hit | output | 1 | Fetch address matches a valid entry |
| pred_taken | output | 1 | Hit whose history predicts taken |
| next_pc | output | ADDR_W | Next fetch address |
| upd_valid | input | 1 | Resolved branch update present |
| upd_pc | input | ADDR_W | Address of the resolved branch |
| upd_target | input | ADDR_W | Resolved target address |
| upd_taken | input | 1 | Resolved outcome, 1 is taken |

## Verification
A wrong replacement choice does not show up at once. It shows up only when the wrongly evicted or wrongly kept branch is fetched again, as a miss where a hit was due, or as a hit on a branch that should be gone. For this reason the random stimulus uses a small address pool that revisits branches within a few cycles. A corrupted history bit shows on the next fetch of that branch, as `next_pc` flipping between target and sequential address. A stale or duplicated tag shows in the first cycle after the update, as a wrong `hit` or a wrong target.

// File: rtl/btb_pkg.sv
package btb_pkg;

    localparam int INSN_BYTES = 4;
    localparam int HIST_MAX   = 16;

    typedef enum logic [1:0] {
        WR_NONE,
        WR_REFRESH,
        WR_FILL,
        WR_EVICT
    } wr_kind_e;

    // Majority-style vote: taken when at least half the recorded outcomes were taken.
    function automatic logic hist_says_taken(input logic [HIST_MAX-1:0] h, input int w);
        int ones;
        ones = 0;
        for (int i = 0; i < HIST_MAX; i++) begin
            if (i < w && h[i]) ones++;
        end
        return (2 * ones >= w);
    endfunction

endpackage

// File: rtl/btb_cam.sv
module btb_cam #(
    parameter  int ENTRIES = 8,
    parameter  int TAG_W   = 32,
    localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [ENTRIES*TAG_W-1:0] tags,
    input  logic [ENTRIES-1:0]       valid,
    input  logic [TAG_W-1:0]         key,
    output logic [ENTRIES-1:0]       match,
    output logic                     any,
    output logic [IDX_W-1:0]         idx
);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = valid[g] && (tags[g*TAG_W +: TAG_W] == key);
    end

    assign any = |match;

    // Entries are unique, so OR-encoding the one-hot vector gives the index.
    always_comb begin
        idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) idx = idx | IDX_W'(i);
        end
    end

endmodule

// File: rtl/btb_victim.sv
module btb_victim #(
    parameter  int ENTRIES = 8,
    localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               flush,
    input  logic [ENTRIES-1:0] valid,
    input  logic               alloc,
    output logic [IDX_W-1:0]   slot,
    output logic               full,
    output logic [IDX_W-1:0]   rr_ptr
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    logic             free_found;
    logic [IDX_W-1:0] free_idx;

    // Lowest-numbered empty slot wins.
    always_comb begin
        free_found = 1'b0;
        free_idx   = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                free_found = 1'b1;
                free_idx   = IDX_W'(i);
            end
        end
    end

    assign full = !free_found;
    assign slot = full ? rr_ptr : free_idx;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            rr_ptr <= '0;
        end else if (alloc && full) begin
            rr_ptr <= (rr_ptr == LAST) ? '0 : rr_ptr + IDX_W'(1);
        end
    end

endmodule

// File: rtl/btb_store.sv
module btb_store
    import btb_pkg::*;
#(
    parameter  int ENTRIES = 8,
    parameter  int ADDR_W  = 32,
    parameter  int HIST_W  = 2,
    localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      flush,
    input  wr_kind_e                  wr_kind,
    input  logic [IDX_W-1:0]          widx,
    input  logic [ADDR_W-1:0]         wtag,
    input  logic [ADDR_W-1:0]         wtgt,
    input  logic                      wtaken,
    output logic [ENTRIES-1:0]        valid,
    output logic [ENTRIES*ADDR_W-1:0] tags,
    output logic [ENTRIES*ADDR_W-1:0] tgts,
    output logic [ENTRIES*HIST_W-1:0] hists
);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        logic              sel;
        logic [HIST_W-1:0] h_cur;
        logic [HIST_W-1:0] h_shift;

        assign sel   = (wr_kind != WR_NONE) && (widx == IDX_W'(g));
        assign h_cur = hists[g*HIST_W +: HIST_W];

        if (HIST_W == 1) begin : g_h1
            assign h_shift = wtaken;
        end else begin : g_hn
            assign h_shift = {h_cur[HIST_W-2:0], wtaken};
        end

        always_ff @(posedge clk) begin
            if (rst || flush) begin
                valid[g] <= 1'b0;
            end else if (sel) begin
                valid[g]                   <= 1'b1;
                tags[g*ADDR_W +: ADDR_W]   <= wtag;
                tgts[g*ADDR_W +: ADDR_W]   <= wtgt;
                hists[g*HIST_W +: HIST_W]  <= (wr_kind == WR_REFRESH) ? h_shift
                                                                     : {HIST_W{wtaken}};
            end
        end
    end

endmodule

// File: rtl/fa_btb.sv
module fa_btb
    import btb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int ADDR_W  = 32,
    parameter int HIST_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic [ADDR_W-1:0] fetch_pc,
    output logic              hit,
    output logic              pred_taken,
    output logic [ADDR_W-1:0] next_pc,
    input  logic              upd_valid,
    input  logic [ADDR_W-1:0] upd_pc,
    input  logic [ADDR_W-1:0] upd_target,
    input  logic              upd_taken
);

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0]        valid;
    logic [ENTRIES*ADDR_W-1:0] tags;
    logic [ENTRIES*ADDR_W-1:0] tgts;
    logic [ENTRIES*HIST_W-1:0] hists;

    logic [ENTRIES-1:0] f_match;
    logic [IDX_W-1:0]   f_idx;
    logic [ENTRIES-1:0] u_match;
    logic               u_hit;
    logic [IDX_W-1:0]   u_idx;

    logic [IDX_W-1:0]   slot;
    logic               full;
    logic [IDX_W-1:0]   rr_ptr;
    wr_kind_e           wr_kind;
    logic [IDX_W-1:0]   widx;
    logic               alloc;

    logic [ADDR_W-1:0]  hit_target;
    logic [HIST_W-1:0]  hit_hist;

    btb_cam #(.ENTRIES(ENTRIES), .TAG_W(ADDR_W)) u_fetch_cam (
        .tags  (tags),
        .valid (valid),
        .key   (fetch_pc),
        .match (f_match),
        .any   (hit),
        .idx   (f_idx)
    );

    btb_cam #(.ENTRIES(ENTRIES), .TAG_W(ADDR_W)) u_upd_cam (
        .tags  (tags),
        .valid (valid),
        .key   (upd_pc),
        .match (u_match),
        .any   (u_hit),
        .idx   (u_idx)
    );

    always_comb begin
        if (flush || !upd_valid) wr_kind = WR_NONE;
        else if (u_hit)          wr_kind = WR_REFRESH;
        else if (full)           wr_kind = WR_EVICT;
        else                     wr_kind = WR_FILL;
    end

    assign alloc = (wr_kind == WR_FILL) || (wr_kind == WR_EVICT);
    assign widx  = u_hit ? u_idx : slot;

    btb_victim #(.ENTRIES(ENTRIES)) u_victim (
        .clk    (clk),
        .rst    (rst),
        .flush  (flush),
        .valid  (valid),
        .alloc  (alloc),
        .slot   (slot),
        .full   (full),
        .rr_ptr (rr_ptr)
    );

    btb_store #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .HIST_W(HIST_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .flush   (flush),
        .wr_kind (wr_kind),
        .widx    (widx),
        .wtag    (upd_pc),
        .wtgt    (upd_target),
        .wtaken  (upd_taken),
        .valid   (valid),
        .tags    (tags),
        .tgts    (tgts),
        .hists   (hists)
    );

    assign hit_target = tgts[f_idx*ADDR_W +: ADDR_W];
    assign hit_hist   = hists[f_idx*HIST_W +: HIST_W];

    assign pred_taken = hit && hist_says_taken(HIST_MAX'(hit_hist), HIST_W);
    assign next_pc    = pred_taken ? hit_target : fetch_pc + ADDR_W'(INSN_BYTES);

endmodule

// File: rtl/btb_checker.sv
module btb_checker #(
    parameter  int ENTRIES = 8,
    parameter  int ADDR_W  = 32,
    localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input logic               clk,
    input logic               rst,
    input logic               flush,
    input logic [ADDR_W-1:0]  fetch_pc,
    input logic               hit,
    input logic               upd_valid,
    input logic [ADDR_W-1:0]  upd_pc,
    input logic [ADDR_W-1:0]  upd_target,
    input logic [ENTRIES-1:0] f_match,
    input logic [ADDR_W-1:0]  hit_target,
    input logic [IDX_W-1:0]   rr_ptr,
    input logic [ENTRIES-1:0] valid
);

    AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (valid == '0 && !hit)); // R1

    AST_UPD_VISIBLE: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && !flush) |=>
            (fetch_pc != $past(upd_pc) || (hit && hit_target == $past(upd_target)))); // R6

    AST_RR_STEP: assert property (@(posedge clk) disable iff (rst)
        (rr_ptr != $past(rr_ptr)) |->
            (rr_ptr == '0 || rr_ptr == $past(rr_ptr) + IDX_W'(1))); // R8

    AST_RR_ONLY_FULL: assert property (@(posedge clk) disable iff (rst)
        (rr_ptr != $past(rr_ptr) && rr_ptr != '0) |-> $past(&valid)); // R8

    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
        $past(flush) |-> (!hit && valid == '0)); // R10

    AST_ONE_MATCH: assert property (@(posedge clk) disable iff (rst)
        $onehot0(f_match)); // R11

endmodule

bind fa_btb btb_checker #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_btb_checker (
    .clk        (clk),
    .rst        (rst),
    .flush      (flush),
    .fetch_pc   (fetch_pc),
    .hit        (hit),
    .upd_valid  (upd_valid),
    .upd_pc     (upd_pc),
    .upd_target (upd_target),
    .f_match    (f_match),
    .hit_target (hit_target),
    .rr_ptr     (rr_ptr),
    .valid      (valid)
);

// File: tb/test_fa_btb.sv
`timescale 1ns/1ps
module test_fa_btb;

    localparam int N  = 8;
    localparam int AW = 32;
    localparam int HW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          flush = 1'b0;
    logic [AW-1:0] fetch_pc = '0;
    logic          hit;
    logic          pred_taken;
    logic [AW-1:0] next_pc;
    logic          upd_valid = 1'b0;
    logic [AW-1:0] upd_pc = '0;
    logic [AW-1:0] upd_target = '0;
    logic          upd_taken = 1'b0;

    always #2.5 clk = ~clk;

    fa_btb #(.ENTRIES(N), .ADDR_W(AW), .HIST_W(HW)) i_fa_btb (
        .clk        (clk),
        .rst        (rst),
        .flush      (flush),
        .fetch_pc   (fetch_pc),
        .hit        (hit),
        .pred_taken (pred_taken),
        .next_pc    (next_pc),
        .upd_valid  (upd_valid),
        .upd_pc     (upd_pc),
        .upd_target (upd_target),
        .upd_taken  (upd_taken)
    );

    int n_checks = 0;
    int n_fail   = 0;

    // Reference model state
    logic          m_valid [N];
    logic [AW-1:0] m_tag   [N];
    logic [AW-1:0] m_tgt   [N];
    logic [HW-1:0] m_hist  [N];
    int            m_rr;

    function automatic logic model_pred(input logic [HW-1:0] h);
        int ones = 0;
        for (int i = 0; i < HW; i++) if (h[i]) ones++;
        return (2 * ones >= HW);
    endfunction

    function automatic int model_find(input logic [AW-1:0] pc);
        for (int i = 0; i < N; i++) if (m_valid[i] && m_tag[i] == pc) return i;
        return -1;
    endfunction

    task automatic model_clear();
        for (int i = 0; i < N; i++) m_valid[i] = 1'b0;
        m_rr = 0;
    endtask

    task automatic model_update(input logic [AW-1:0] pc, input logic [AW-1:0] tgt, input logic tk);
        int k;
        k = model_find(pc);
        if (k >= 0) begin
            m_tgt[k]  = tgt;
            m_hist[k] = {m_hist[k][HW-2:0], tk};
        end else begin
            for (int i = N - 1; i >= 0; i--) if (!m_valid[i]) k = i;
            if (k < 0) begin
                k    = m_rr;
                m_rr = (m_rr + 1) % N;
            end
            m_valid[k] = 1'b1;
            m_tag[k]   = pc;
            m_tgt[k]   = tgt;
            m_hist[k]  = {HW{tk}};
        end
    endtask

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // One cycle: drive, check lookup against model, clock, advance model.
    task automatic step(input logic [AW-1:0] fpc, input logic uv, input logic [AW-1:0] upc,
                        input logic [AW-1:0] utgt, input logic utk, input logic fl,
                        input string ctx);
        int            k;
        logic          e_hit, e_pred;
        logic [AW-1:0] e_next;
        fetch_pc   = fpc;
        upd_valid  = uv;
        upd_pc     = upc;
        upd_target = utgt;
        upd_taken  = utk;
        flush      = fl;
        #1;
        k      = model_find(fpc);
        e_hit  = (k >= 0);
        e_pred = e_hit && model_pred(m_hist[k]);
        e_next = e_pred ? m_tgt[k] : fpc + 32'd4;
        chk(hit == e_hit, {"R2 ", ctx}, "hit", AW'(hit), AW'(e_hit));
        chk(pred_taken == e_pred, {"R5 ", ctx}, "pred_taken", AW'(pred_taken), AW'(e_pred));
        chk(next_pc == e_next, e_pred ? {"R3 ", ctx} : {"R4 ", ctx}, "next_pc", next_pc, e_next);
        @(posedge clk);
        if (fl) model_clear();
        else if (uv) model_update(upc, utgt, utk);
        @(negedge clk);
    endtask

    task automatic look(input logic [AW-1:0] fpc, input string ctx);
        step(fpc, 1'b0, '0, '0, 1'b0, 1'b0, ctx);
    endtask

    localparam logic [AW-1:0] PA = 32'h0000_1000;

    initial begin
        logic [AW-1:0] pool [12];
        model_clear();
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: empty after reset
        look(PA, "R1 after reset");
        look(32'h0, "R1 after reset");
        look(32'hFFFF_FFFC, "R1 after reset wrap");

        // R9: same-cycle update invisible; R7 fill into entry 0
        step(PA, 1'b1, PA, 32'h2000, 1'b1, 1'b0, "R9 same cycle");
        look(PA, "R7 R3 taken hit");
        // R6 refresh: target change, history 11 -> 10 still taken
        step(PA, 1'b1, PA, 32'h3000, 1'b0, 1'b0, "R9 refresh same cycle");
        look(PA, "R6 R5 one of two taken");
        // history 10 -> 00: not taken, sequential
        step(PA, 1'b1, PA, 32'h3000, 1'b0, 1'b0, "R6");
        look(PA, "R5 R4 not-taken hit");
        // back toward taken: 00 -> 01
        step(PA, 1'b1, PA, 32'h3800, 1'b1, 1'b0, "R6");
        look(PA, "R5 R6 retaken");

        // R7: fill remaining slots
        for (int i = 1; i < N; i++)
            step(PA, 1'b1, 32'h4000 + 32'(i * 16), 32'h9000 + 32'(i * 4), 1'b1, 1'b0, "R7 fill");
        for (int i = 1; i < N; i++)
            look(32'h4000 + 32'(i * 16), "R7 filled");
        // R8: replacements follow the round-robin pointer 0,1,2
        step(PA, 1'b1, 32'h5000, 32'hA000, 1'b1, 1'b0, "R8 evict");
        look(PA, "R8 victim 0 gone");
        look(32'h5000, "R8 new entry");
        step(PA, 1'b1, 32'h5010, 32'hA010, 1'b0, 1'b0, "R8 evict");
        look(32'h4010, "R8 victim 1 gone");
        look(32'h4020, "R8 entry 2 kept");
        look(32'h5010, "R8 R11 not-taken fill");

        // R10: flush beats a simultaneous update
        step(32'h5000, 1'b1, 32'h6000, 32'hB000, 1'b1, 1'b1, "R10 flush+update");
        look(32'h6000, "R10 update dropped");
        look(32'h5000, "R10 cleared");
        step(32'h6000, 1'b1, 32'h6000, 32'hB000, 1'b1, 1'b0, "R10 R7 refill");
        look(32'h6000, "R10 R7 refill visible");

        // Random traffic over a small pool to force reuse and eviction
        for (int i = 0; i < 12; i++) pool[i] = 32'h8000 + 32'(i * 4);
        for (int t = 0; t < 4000; t++) begin
            logic [AW-1:0] f, u;
            logic          uv, fl;
            f  = ($urandom % 8 == 0) ? ($urandom & 32'hFFFF_FFFC) : pool[$urandom % 12];
            u  = pool[$urandom % 12];
            uv = ($urandom % 3 != 0);
            fl = ($urandom % 128 == 0);
            step(f, uv, u, $urandom & 32'hFFFF_FFFC, 1'($urandom), fl, "R6 R7 R8 R11 random");
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule